// File: doc/BRIEF.md
# Data Address Translation Buffer

This block translates the effective address of a load or store into a real address using 4 kB pages. It holds 64 sets of two ways. Each entry pairs an effective page tag with the translation and permission fields of a radix-format page table entry. A lookup goes in on one clock edge, and its verdict comes out registered on the next. The verdict gives a hit or miss indication, the real address, a cache-inhibit flag, and four independent fault causes: segment, reference/change, privilege and read/write.

The same block takes a maintenance command. It carries a control word, made of a page number and a three-bit code, together with a data word. Depending on the code, the command drops every entry, drops the one entry for a given page, or writes the data word as a new entry for that page. When translation is disabled, the address passes through untouched and no checks apply.

Top module: `dxlat_tlb`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. In every cycle where `rsp_valid` is low, all other response outputs are zero. `rsp_ra` is zero unless `rsp_hit` is high.
- R2: After reset every entry is invalid, so a translated lookup reports a miss. During reset and in the first cycle after it, `rsp_valid` is low.
- R3: The command code is `cmd_ctl[11:9]`. If the code is not 3'b001 and either bit 10 or bit 11 is set, every entry in both ways becomes invalid. This includes code 3'b011.
- R4: A command whose code is 3'b000 invalidates only the entry in set `cmd_ctl[17:12]` whose tag equals `cmd_ctl[63:18]`. A different tag in the same set index leaves all entries intact.
- R5: Code 3'b001 loads an entry for page `cmd_ctl[63:12]` from `cmd_pte`. The real page number comes from `cmd_pte[55:12]`, and the real address on a hit is {`cmd_pte[55:12]`, `lk_ea[11:0]`}.
- R6: A lookup uses `lk_ea[17:12]` as the set index and `lk_ea[63:18]` as the tag. Two pages with the same index and different tags can both hit at the same time.
- R7: A load replaces the way that already holds the same page, if there is one. Otherwise it replaces the way named by the set's one-bit pointer, which is 0 after reset. Every load into a set toggles that set's pointer, so a third distinct page evicts the way loaded least recently.
- R8: On a hit, `rsp_ref_fault` is set if the referenced bit `pte[8]` is 0. It is also set for a store (`lk_store`=1) if the changed bit `pte[7]` is 0.
- R9: On a hit, `rsp_priv_fault` is set when the privileged-only bit `pte[3]` is 1 and the access is from problem state (`lk_user`=1).
- R10: On a hit, `rsp_rw_fault` is set for a store when the write bit `pte[1]` is 0. It is set for a load when both the read bit `pte[2]` and `pte[1]` are 0.
- R11: On a hit, `rsp_inhibit` equals the cache-inhibit attribute bit `pte[5]`.
- R12: With translation enabled and `lk_ea[63:62]` equal to 01 or 10, only `rsp_seg_fault` is set. Hit, miss and all other faults stay low. Quadrants 00 and 11 are looked up normally.
- R13: With `lk_xlate`=0, the response is a hit with `rsp_ra` = `lk_ea[55:0]`. No fault, miss or inhibit flag is set.
- R14: A lookup in the same cycle as a command sees the entries as they were before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_ea | input | 64 | Effective address to translate |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = problem (user) state |
| lk_xlate | input | 1 | 1 = data translation enabled |
| cmd_valid | input | 1 | Maintenance command this cycle |
| cmd_ctl | input | 64 | Page number [63:12] and command code [11:9] |
| cmd_pte | input | 64 | Entry data for a load command |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found (or translation disabled) |
| rsp_miss | output | 1 | No matching entry |
| rsp_ra | output | 56 | Real address |
| rsp_inhibit | output | 1 | Access is cache-inhibited |
| rsp_seg_fault | output | 1 | Address quadrant not translatable |
| rsp_ref_fault | output | 1 | Referenced/changed bit check failed |
| rsp_priv_fault | output | 1 | Privileged page accessed from problem state |
| rsp_rw_fault | output | 1 | Read/write permission check failed |

## Verification
All response outputs come from a single register stage. A lookup driven before a rising edge therefore has its verdict visible during the following cycle. The bench drives on the falling edge, lets exactly one rising edge pass, and samples at the next falling edge.

A command applied in one cycle changes the entries at that same rising edge. A lookup issued in the next cycle sees the new contents, and its result is sampled one cycle after that. The same-cycle case checks that a lookup paired with a load still reports the old contents. A follow-up lookup then checks that the new entry is present.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;

    // Bit positions inside the entry data word (behaviour depends on them)
    localparam int unsigned PTE_W    = 64;
    localparam int unsigned PB_REF   = 8;
    localparam int unsigned PB_CHG   = 7;
    localparam int unsigned PB_NC    = 5;
    localparam int unsigned PB_PRIV  = 3;
    localparam int unsigned PB_RD    = 2;
    localparam int unsigned PB_WR    = 1;

    // Command code field position in the control word
    localparam int unsigned CODE_LO  = 9;
    localparam logic [2:0]  CODE_LOAD = 3'b001;

    typedef enum logic [1:0] {
        TC_NONE,
        TC_FLUSH_ALL,
        TC_FLUSH_PAGE,
        TC_LOAD
    } tlb_cmd_e;

    typedef struct packed {
        logic refd;
        logic chg;
        logic nc;
        logic priv;
        logic rd;
        logic wr;
    } pte_perm_t;

    typedef struct packed {
        logic hit;
        logic miss;
        logic inhibit;
        logic seg;
        logic ref_f;
        logic priv_f;
        logic rw_f;
    } rsp_flags_t;

    function automatic pte_perm_t perm_extract(input logic [PTE_W-1:0] pte);
        pte_perm_t p;
        p.refd = pte[PB_REF];
        p.chg  = pte[PB_CHG];
        p.nc   = pte[PB_NC];
        p.priv = pte[PB_PRIV];
        p.rd   = pte[PB_RD];
        p.wr   = pte[PB_WR];
        return p;
    endfunction

    function automatic rsp_flags_t perm_eval(input pte_perm_t p,
                                             input logic store,
                                             input logic user);
        rsp_flags_t f;
        f         = '0;
        f.hit     = 1'b1;
        f.inhibit = p.nc;
        f.ref_f   = !p.refd || (store && !p.chg);
        f.priv_f  = p.priv && user;
        f.rw_f    = store ? !p.wr : !(p.rd || p.wr);
        return f;
    endfunction

endpackage

// File: rtl/dxlat_cmd_dec.sv
module dxlat_cmd_dec
    import dxlat_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] code,
    output tlb_cmd_e   op
);

    always_comb begin
        if (!cmd_valid)
            op = TC_NONE;
        else if (code == CODE_LOAD)
            op = TC_LOAD;
        else if (code[1] || code[2])
            op = TC_FLUSH_ALL;
        else
            op = TC_FLUSH_PAGE;
    end

endmodule

// File: rtl/dxlat_way.sv
module dxlat_way
    import dxlat_pkg::*;
#(
    parameter int unsigned SET_BITS = 6,
    parameter int unsigned TAG_W    = 46,
    parameter int unsigned RPN_W    = 44
) (
    input  logic                clk,
    input  logic                rst,
    // lookup read port
    input  logic [SET_BITS-1:0] lk_idx,
    input  logic [TAG_W-1:0]    lk_tag,
    output logic                lk_hit,
    output pte_perm_t           lk_perm,
    output logic [RPN_W-1:0]    lk_rpn,
    // command port
    input  logic [SET_BITS-1:0] cm_idx,
    input  logic [TAG_W-1:0]    cm_tag,
    output logic                cm_hit,
    input  logic                wr_en,
    input  pte_perm_t           wr_perm,
    input  logic [RPN_W-1:0]    wr_rpn,
    input  logic                inv_page,
    input  logic                inv_all
);

    localparam int unsigned SETS = 1 << SET_BITS;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    pte_perm_t        perm_q [SETS];
    logic [RPN_W-1:0] rpn_q  [SETS];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_perm = perm_q[lk_idx];
    assign lk_rpn  = rpn_q[lk_idx];
    assign cm_hit  = vld_q[cm_idx] && (tag_q[cm_idx] == cm_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (inv_all) begin
            vld_q <= '0;
        end else begin
            if (wr_en)
                vld_q[cm_idx] <= 1'b1;
            if (inv_page && cm_hit)
                vld_q[cm_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[cm_idx]  <= cm_tag;
            perm_q[cm_idx] <= wr_perm;
            rpn_q[cm_idx]  <= wr_rpn;
        end
    end

    // R3
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (vld_q == '0));

    // R4
    page_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_page && cm_hit && !inv_all) |=> !vld_q[$past(cm_idx)]);

endmodule

// File: rtl/dxlat_resolve.sv
module dxlat_resolve
    import dxlat_pkg::*;
#(
    parameter int unsigned RA_W      = 56,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned RPN_W     = 44
) (
    input  logic             xlate,
    input  logic             store,
    input  logic             user,
    input  logic [1:0]       ea_quad,
    input  logic [RA_W-1:0]  ea_low,
    input  logic [1:0]       way_hit,
    input  pte_perm_t        way_perm [2],
    input  logic [RPN_W-1:0] way_rpn  [2],
    output rsp_flags_t       flags,
    output logic [RA_W-1:0]  ra
);

    pte_perm_t        sel_perm;
    logic [RPN_W-1:0] sel_rpn;

    assign sel_perm = way_hit[0] ? way_perm[0] : way_perm[1];
    assign sel_rpn  = way_hit[0] ? way_rpn[0]  : way_rpn[1];

    always_comb begin
        flags = '0;
        ra    = '0;
        if (!xlate) begin
            flags.hit = 1'b1;
            ra        = ea_low;
        end else if (ea_quad == 2'b01 || ea_quad == 2'b10) begin
            flags.seg = 1'b1;
        end else if (way_hit == 2'b00) begin
            flags.miss = 1'b1;
        end else begin
            flags = perm_eval(sel_perm, store, user);
            ra    = {sel_rpn, ea_low[PAGE_BITS-1:0]};
        end
    end

endmodule

// File: rtl/dxlat_tlb.sv
module dxlat_tlb
    import dxlat_pkg::*;
#(
    parameter int unsigned EA_W      = 64,
    parameter int unsigned RA_W      = 56,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned SET_BITS  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [EA_W-1:0] lk_ea,
    input  logic            lk_store,
    input  logic            lk_user,
    input  logic            lk_xlate,
    input  logic            cmd_valid,
    input  logic [EA_W-1:0] cmd_ctl,
    input  logic [63:0]     cmd_pte,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic            rsp_miss,
    output logic [RA_W-1:0] rsp_ra,
    output logic            rsp_inhibit,
    output logic            rsp_seg_fault,
    output logic            rsp_ref_fault,
    output logic            rsp_priv_fault,
    output logic            rsp_rw_fault
);

    localparam int unsigned WAYS  = 2;
    localparam int unsigned SETS  = 1 << SET_BITS;
    localparam int unsigned TAG_LO = PAGE_BITS + SET_BITS;
    localparam int unsigned TAG_W = EA_W - TAG_LO;
    localparam int unsigned RPN_W = RA_W - PAGE_BITS;

    // ---------------- address fields ----------------
    logic [SET_BITS-1:0] lk_idx, cm_idx;
    logic [TAG_W-1:0]    lk_tag, cm_tag;

    assign lk_idx = lk_ea[TAG_LO-1:PAGE_BITS];
    assign lk_tag = lk_ea[EA_W-1:TAG_LO];
    assign cm_idx = cmd_ctl[TAG_LO-1:PAGE_BITS];
    assign cm_tag = cmd_ctl[EA_W-1:TAG_LO];

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_ctl[CODE_LO-1:0], cmd_pte[63:RA_W],
                               cmd_pte[PAGE_BITS-1:PB_REF+1], cmd_pte[6],
                               cmd_pte[4], cmd_pte[0], lk_ea[EA_W-3:RA_W]};

    // ---------------- command decode ----------------
    tlb_cmd_e cmd_op;

    dxlat_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .code      (cmd_ctl[CODE_LO+2:CODE_LO]),
        .op        (cmd_op)
    );

    logic ld_fire;
    assign ld_fire = (cmd_op == TC_LOAD);

    // ---------------- replacement pointer ----------------
    logic [SETS-1:0] rr_q;
    logic [WAYS-1:0] cm_hit;
    logic            wr_way;

    assign wr_way = cm_hit[0] ? 1'b0 : (cm_hit[1] ? 1'b1 : rr_q[cm_idx]);

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (ld_fire)
            rr_q[cm_idx] <= ~rr_q[cm_idx];
    end

    // ---------------- storage ways ----------------
    logic [WAYS-1:0]  lk_hit;
    pte_perm_t        lk_perm [WAYS];
    logic [RPN_W-1:0] lk_rpn  [WAYS];
    pte_perm_t        new_perm;

    assign new_perm = perm_extract(cmd_pte);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dxlat_way #(
            .SET_BITS (SET_BITS),
            .TAG_W    (TAG_W),
            .RPN_W    (RPN_W)
        ) u_way (
            .clk      (clk),
            .rst      (rst),
            .lk_idx   (lk_idx),
            .lk_tag   (lk_tag),
            .lk_hit   (lk_hit[w]),
            .lk_perm  (lk_perm[w]),
            .lk_rpn   (lk_rpn[w]),
            .cm_idx   (cm_idx),
            .cm_tag   (cm_tag),
            .cm_hit   (cm_hit[w]),
            .wr_en    (ld_fire && (wr_way == 1'(w))),
            .wr_perm  (new_perm),
            .wr_rpn   (cmd_pte[RA_W-1:PAGE_BITS]),
            .inv_page (cmd_op == TC_FLUSH_PAGE),
            .inv_all  (cmd_op == TC_FLUSH_ALL)
        );
    end

    // ---------------- verdict ----------------
    rsp_flags_t      flags_d, flags_q;
    logic [RA_W-1:0] ra_d, ra_q;
    logic            valid_q;

    dxlat_resolve #(
        .RA_W      (RA_W),
        .PAGE_BITS (PAGE_BITS),
        .RPN_W     (RPN_W)
    ) u_res (
        .xlate    (lk_xlate),
        .store    (lk_store),
        .user     (lk_user),
        .ea_quad  (lk_ea[EA_W-1:EA_W-2]),
        .ea_low   (lk_ea[RA_W-1:0]),
        .way_hit  (lk_hit),
        .way_perm (lk_perm),
        .way_rpn  (lk_rpn),
        .flags    (flags_d),
        .ra       (ra_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            flags_q <= '0;
            ra_q    <= '0;
        end else begin
            valid_q <= lk_valid;
            flags_q <= lk_valid ? flags_d : '0;
            ra_q    <= lk_valid ? ra_d : '0;
        end
    end

    assign rsp_valid      = valid_q;
    assign rsp_hit        = flags_q.hit;
    assign rsp_miss       = flags_q.miss;
    assign rsp_inhibit    = flags_q.inhibit;
    assign rsp_seg_fault  = flags_q.seg;
    assign rsp_ref_fault  = flags_q.ref_f;
    assign rsp_priv_fault = flags_q.priv_f;
    assign rsp_rw_fault   = flags_q.rw_f;
    assign rsp_ra         = ra_q;

    // ---------------- checks ----------------
    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R13
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_xlate) |=> (rsp_hit && !rsp_miss && !rsp_seg_fault
            && !rsp_ref_fault && !rsp_priv_fault && !rsp_rw_fault
            && rsp_ra == $past(lk_ea[RA_W-1:0])));

    // R12
    seg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_seg_fault |-> (!rsp_hit && !rsp_miss && !rsp_ref_fault));

    // R7
    rr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ld_fire |=> (rr_q != $past(rr_q)));

    // R7
    single_way_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lk_hit) <= 1);

endmodule

// File: tb/dxlat_tlb_bench.sv
`timescale 1ns/1ps
module dxlat_tlb_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_ea = '0;
    logic        lk_store = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_xlate = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [63:0] cmd_ctl = '0;
    logic [63:0] cmd_pte = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_inhibit;
    logic        rsp_seg_fault, rsp_ref_fault, rsp_priv_fault, rsp_rw_fault;
    logic [55:0] rsp_ra;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dxlat_tlb u_dxlat_tlb (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_store(lk_store),
        .lk_user(lk_user), .lk_xlate(lk_xlate),
        .cmd_valid(cmd_valid), .cmd_ctl(cmd_ctl), .cmd_pte(cmd_pte),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_ra(rsp_ra), .rsp_inhibit(rsp_inhibit),
        .rsp_seg_fault(rsp_seg_fault), .rsp_ref_fault(rsp_ref_fault),
        .rsp_priv_fault(rsp_priv_fault), .rsp_rw_fault(rsp_rw_fault)
    );

    // flags order: hit miss inhibit seg ref priv rw
    typedef struct packed {
        logic        is_cmd;
        logic [63:0] a;
        logic [63:0] b;
        logic        st;
        logic        us;
        logic        xl;
        logic [6:0]  exp;
        logic [55:0] ra;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] PTE_A = 64'h0000_0000_ABCD_E186;
    localparam logic [63:0] PTE_B = 64'h0000_0000_1111_112C;
    localparam logic [63:0] PTE_D = 64'h0000_0000_4444_4186;
    localparam int NV = 36;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 64'h0000_0000_0001_2200, PTE_A, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        '{1'b1, 64'h0000_0000_0005_2200, PTE_B, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        // R6 A user load / store, both pages in set 0x12
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b1, 1'b1, 7'b1000000, 56'h00_0000_ABCD_E345, 4'd6},
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b1, 1'b1, 1'b1, 7'b1000000, 56'h00_0000_ABCD_E345, 4'd6},
        // R11 inhibit on B
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1010000, 56'h00_0000_1111_1ABC, 4'd11},
        // R9 privileged page from user
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b0, 1'b1, 1'b1, 7'b1010010, 56'h00_0000_1111_1ABC, 4'd9},
        // R10 store without C and W: ref and rw faults
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b1, 1'b0, 1'b1, 7'b1010101, 56'h00_0000_1111_1ABC, 4'd10},
        '{1'b1, 64'h0000_0000_0009_2200, 64'h0000_0000_2222_2002, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        // R7 third page evicts A
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd7},
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1010000, 56'h00_0000_1111_1ABC, 4'd7},
        // R8 C has R=0
        '{1'b0, 64'h0000_0000_0009_2010, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1000100, 56'h00_0000_2222_2010, 4'd8},
        '{1'b0, 64'h0000_0000_0009_2010, 64'h0, 1'b1, 1'b0, 1'b1, 7'b1000100, 56'h00_0000_2222_2010, 4'd8},
        '{1'b1, 64'h0000_0000_0005_2200, 64'h0000_0000_3333_3186, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd7},
        '{1'b1, 64'h0000_0000_0001_2200, PTE_A, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd7},
        // R7 reload of B kept its way; A evicted C
        '{1'b0, 64'h0000_0000_0009_2010, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd7},
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1000000, 56'h00_0000_3333_3ABC, 4'd7},
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1000000, 56'h00_0000_ABCD_E345, 4'd7},
        // R4 drop page B
        '{1'b1, 64'h0000_0000_0005_2000, 64'h0, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd4},
        '{1'b0, 64'h0000_0000_0005_2ABC, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd4},
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1000000, 56'h00_0000_ABCD_E345, 4'd4},
        '{1'b1, 64'h0000_0000_0000_3200, PTE_D, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        '{1'b1, 64'h0000_0000_0004_3000, 64'h0, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd4},
        '{1'b0, 64'h0000_0000_0000_3008, 64'h0, 1'b0, 1'b0, 1'b1, 7'b1000000, 56'h00_0000_4444_4008, 4'd4},
        // R3 bit 10 drops all
        '{1'b1, 64'h0000_0000_0000_0400, 64'h0, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd3},
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd3},
        '{1'b0, 64'h0000_0000_0000_3008, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd3},
        '{1'b1, 64'h0000_0000_0000_3200, PTE_D, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        // R3 code 011 is a flush, not a load
        '{1'b1, 64'h0000_0000_0000_3600, PTE_D, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd3},
        '{1'b0, 64'h0000_0000_0000_3008, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd3},
        '{1'b1, 64'h0000_0000_0001_2200, PTE_A, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd5},
        '{1'b1, 64'h0000_0000_0000_0800, 64'h0, 1'b0, 1'b0, 1'b0, 7'b0, 56'h0, 4'd3},
        '{1'b0, 64'h0000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd3},
        // R12 quadrants 01 and 10 fault, 11 looks up
        '{1'b0, 64'h4000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0001000, 56'h0, 4'd12},
        '{1'b0, 64'h8000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0001000, 56'h0, 4'd12},
        '{1'b0, 64'hC000_0000_0001_2345, 64'h0, 1'b0, 1'b0, 1'b1, 7'b0100000, 56'h0, 4'd12},
        // R13 translation off
        '{1'b0, 64'h4000_0000_0001_2345, 64'h0, 1'b1, 1'b1, 1'b0, 7'b1000000, 56'h00_0000_0001_2345, 4'd13}
    };

    task automatic step(input logic cv, input logic [63:0] ctl, input logic [63:0] pte,
                        input logic lv, input logic [63:0] ea,
                        input logic st, input logic us, input logic xl);
        @(negedge clk);
        cmd_valid = cv; cmd_ctl = ctl; cmd_pte = pte;
        lk_valid = lv; lk_ea = ea; lk_store = st; lk_user = us; lk_xlate = xl;
        @(negedge clk);
        cmd_valid = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic check_rsp(input int req, input logic ev,
                             input logic [6:0] ef, input logic [55:0] era);
        logic [6:0] af;
        af = {rsp_hit, rsp_miss, rsp_inhibit, rsp_seg_fault,
              rsp_ref_fault, rsp_priv_fault, rsp_rw_fault};
        checks++;
        if (rsp_valid !== ev || af !== ef || rsp_ra !== era) begin
            errors++;
            $display("FAIL R%0d: valid=%b flags=%b ra=%h expected valid=%b flags=%b ra=%h",
                     req, rsp_valid, af, rsp_ra, ev, ef, era);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 response idle during reset
        check_rsp(2, 1'b0, 7'b0, 56'h0);
        rst = 1'b0;
        @(negedge clk);
        // R2 first cycle after reset
        check_rsp(2, 1'b0, 7'b0, 56'h0);
        // R2 empty after reset: lookup misses
        step(1'b0, '0, '0, 1'b1, 64'h0000_0000_0001_2345, 1'b0, 1'b0, 1'b1);
        check_rsp(2, 1'b1, 7'b0100000, 56'h0);
        // R1 a cycle without a lookup gives no response
        @(negedge clk);
        check_rsp(1, 1'b0, 7'b0, 56'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_cmd) begin
                step(1'b1, TBL[i].a, TBL[i].b, 1'b0, '0, 1'b0, 1'b0, 1'b0);
                // R1 command alone produces no response
                if (i == 0) check_rsp(1, 1'b0, 7'b0, 56'h0);
            end else begin
                step(1'b0, '0, '0, 1'b1, TBL[i].a, TBL[i].st, TBL[i].us, TBL[i].xl);
                check_rsp(int'(TBL[i].req), 1'b1, TBL[i].exp, TBL[i].ra);
            end
        end

        // R14 lookup alongside a load sees the old contents
        step(1'b1, 64'h0000_0000_0000_7200, 64'h0000_0000_5555_5186,
             1'b1, 64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1);
        check_rsp(14, 1'b1, 7'b0100000, 56'h0);
        // R5 the loaded entry is visible on the next lookup
        step(1'b0, '0, '0, 1'b1, 64'h0000_0000_0000_7FFF, 1'b0, 1'b0, 1'b1);
        check_rsp(5, 1'b1, 7'b1000000, 56'h00_0000_5555_5FFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule